// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Node-Address Filtering

This block is a full-duplex asynchronous serial port. A programmable divider produces an oversampling tick at sixteen times the bit rate, and both directions derive their timing from it. The transmitter drains an eight-entry queue and sends each word as one frame. The receiver checks each incoming frame and pushes it into a second eight-entry queue. Each received word is stored together with three status bits: parity mismatch, bad stop bit and line break. When the host pops a word, it gets that word's own error status with it.

Frames are one start bit, eight or nine data bits sent LSB first, an optional parity bit, and one stop bit. In nine-bit mode the ninth data bit separates address words (1) from data words (0). This lets several nodes share one pair of lines. The receiver keeps only the traffic meant for its own programmed address. The host side has a write strobe, a read strobe, a registered read return and a few level and sticky flags.

Top module: `sercom_uart`

## Requirements
- R1: One bit lasts 16*(cfg_div+1) clock cycles. `txd` idles high. A transmitted frame is a low start bit, then data LSB first, then the optional parity bit, then a high stop bit.
- R2: The transmit queue holds 8 words. A write while `tx_full` is high is dropped and sets the sticky `tx_ovf`.
- R3: The receive queue holds 8 words in arrival order. `rd_valid` pulses one cycle after `rd_en`, and the word appears on `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk`.
- R4: A read while `rx_empty` is high returns all zeros and sets the sticky `rx_udf`.
- R5: With `cfg_par_en` set, the parity bit follows the data bits. It is the XOR of the data bits, inverted when `cfg_par_odd` is 1. It is generated on transmit and checked on receive, and a mismatch sets the word's `rd_perr`.
- R6: A stop bit sampled low sets the word's `rd_ferr`.
- R7: A break is a frame whose data, parity and stop bits are all low. It is stored with `rd_brk` and `rd_ferr` set. The receiver then waits for the line to go high before it looks for the next start bit, so a long low level gives exactly one word.
- R8: With `cfg_nine_bit` set, a ninth data bit follows bit 7 on both paths and appears as `rd_data[8]`. In eight-bit mode, `rd_data[8]` reads 0 and `wr_data[8]` is ignored.
- R9: In nine-bit mode, data words are discarded until an address word whose low byte equals `cfg_node_addr` arrives. That address word is stored. Later data words are stored until an address word with a different value arrives; that address word is discarded. Break words are always stored.
- R10: A start bit counts only if the line is still low at the 8th oversampling tick. A shorter low pulse produces no word.
- R11: A word that would be stored while the receive queue is full is dropped and sets the sticky `rx_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_div | input | DIV_W | Oversampling tick period minus one, in clocks |
| cfg_nine_bit | input | 1 | Enables nine-bit address-marking frames |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | Selects odd parity |
| cfg_node_addr | input | 8 | Address this node answers to |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 9 | Word to send; bit 8 is used only in nine-bit mode |
| rd_en | input | 1 | Pop one word from the receive queue |
| rd_valid | output | 1 | Read return strobe |
| rd_data | output | 9 | Received word |
| rd_perr | output | 1 | Parity mismatch for this word |
| rd_ferr | output | 1 | Stop bit was low for this word |
| rd_brk | output | 1 | This word was a break |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky: a write was dropped |
| rx_udf | output | 1 | Sticky: an empty queue was read |
| rx_ovr | output | 1 | Sticky: a received word was dropped |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench drives a long low level on the line. A receiver that restarts the hunt while the line is still low would store a chain of break words instead of one. It sends a four-clock low pulse, which a receiver that skips the mid-bit confirmation would turn into a phantom word. It interleaves matching and non-matching address words with data words. A filter that misses the closing address, or drops the opening one, would show extra or missing words on readback. It also fills both queues past capacity. An off-by-one in the full flag would either accept a tenth write or lose the ninth.

// File: rtl/sercom_pkg.sv
`timescale 1ns/1ps
package sercom_pkg;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned OSR    = 16;
  localparam int unsigned OSR_W  = $clog2(OSR);

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  localparam int unsigned RXW_W = $bits(rx_word_t);

  typedef enum logic [1:0] {RX_HUNT, RX_SHIFT, RX_WAIT_HIGH} rx_state_e;
  typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_e;

  // parity over the active data bits; odd inverts the XOR (R5)
  function automatic logic frame_parity(logic [DATA_W-1:0] d, logic nine, logic odd);
    logic [DATA_W-1:0] m;
    m = nine ? d : {1'b0, d[DATA_W-2:0]};
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/sercom_baud.sv
`timescale 1ns/1ps
module sercom_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q >= div);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/sercom_fifo.sv
`timescale 1ns/1ps
module sercom_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 8   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic         do_push, do_pop;

  always_comb begin
    empty   = (wptr_q == rptr_q);
    full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = do_push ? wptr_q + 1'b1 : wptr_q;
    rptr_d  = do_pop  ? rptr_q + 1'b1 : rptr_q;
    rdata   = mem[rptr_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/sercom_tx.sv
`timescale 1ns/1ps
module sercom_tx
  import sercom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  localparam int unsigned FRAME_W = DATA_W + 3;  // start, data, parity, stop

  tx_state_e          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frame;
  logic [OSR_W-1:0]   cnt_q, cnt_d;
  logic [3:0]         left_q, left_d, nbits;

  always_comb begin
    // frame image, LSB first on the wire (R1, R5, R8)
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || nine) frame[i+1] = data[i];
    end
    if (par_en) frame[nine ? DATA_W + 1 : DATA_W] = frame_parity(data, nine, par_odd);
    nbits = 4'd10 + {3'b000, nine} + {3'b000, par_en};

    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    pop    = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (have_data) begin
          pop    = 1'b1;
          sh_d   = frame;
          cnt_d  = '0;
          left_d = nbits;
          st_d   = TX_SHIFT;
        end
      end
      default: begin
        if (tick) begin
          if (cnt_q == OSR_W'(OSR - 1)) begin
            cnt_d  = '0;
            sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
            left_d = left_q - 1'b1;
            if (left_q == 4'd1) st_d = TX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

  assign txd  = sh_q[0];
  assign busy = (st_q == TX_SHIFT);
endmodule

// File: rtl/sercom_rx.sv
`timescale 1ns/1ps
module sercom_rx
  import sercom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd,
  input  logic     nine,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     valid,
  output rx_word_t word
);
  localparam int unsigned SH_W = DATA_W + 2;  // data, parity, stop

  rx_state_e         st_q, st_d;
  logic [1:0]        sync_q;
  logic              line;
  logic [OSR_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d, last_idx;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              valid_q, valid_d;
  rx_word_t          word_q, word_d;
  logic [DATA_W-1:0] dbits;
  logic              pbit;

  assign line = sync_q[1];

  always_comb begin
    last_idx = 4'd8 + {3'b000, nine} + {3'b000, par_en};
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    valid_d  = 1'b0;
    word_d   = word_q;
    dbits    = '0;
    pbit     = 1'b0;
    case (st_q)
      RX_HUNT: begin
        if (tick) begin
          if (!line) begin
            // start confirmed at mid-bit (R10)
            if (cnt_q == OSR_W'(OSR/2 - 1)) begin
              st_d  = RX_SHIFT;
              cnt_d = '0;
              idx_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
      end
      RX_SHIFT: begin
        if (tick) begin
          if (cnt_q == OSR_W'(OSR - 1)) begin
            cnt_d = '0;
            if (idx_q < 4'(SH_W)) sh_d[idx_q] = line;
            idx_d = idx_q + 1'b1;
            if (idx_q == last_idx) begin
              dbits       = nine ? sh_d[DATA_W-1:0] : {1'b0, sh_d[DATA_W-2:0]};
              pbit        = par_en && sh_d[nine ? DATA_W : DATA_W - 1];
              valid_d     = 1'b1;
              word_d.data = dbits;
              word_d.perr = par_en && (pbit != frame_parity(dbits, nine, par_odd));  // R5
              word_d.ferr = !line;                                                    // R6
              word_d.brk  = !line && (dbits == '0) && !pbit;                          // R7
              st_d        = line ? RX_HUNT : RX_WAIT_HIGH;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (line) begin
          st_d  = RX_HUNT;
          cnt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_HUNT;
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      st_q    <= st_d;
      sync_q  <= {sync_q[0], rxd};
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign valid = valid_q;
  assign word  = word_q;
endmodule

// File: rtl/sercom_uart.sv
`timescale 1ns/1ps
module sercom_uart
  import sercom_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_nine_bit,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [7:0]       cfg_node_addr,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [8:0]       rd_data,
  output logic             rd_perr,
  output logic             rd_ferr,
  output logic             rd_brk,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             tx_ovf,
  output logic             rx_udf,
  output logic             rx_ovr,
  input  logic             rxd,
  output logic             txd
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              tick;
  logic              tx_pop, tx_busy, tx_push;
  logic [DATA_W-1:0] tx_head;
  logic              rx_valid, rx_push, rx_pop, keep, addr_hit;
  rx_word_t          rx_word, rx_head, rd_word_q, rd_word_d;
  logic              rd_valid_q, rd_valid_d;
  logic              tx_ovf_q, tx_ovf_d, rx_udf_q, rx_udf_d, rx_ovr_q, rx_ovr_d;
  logic              match_q, match_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sercom_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_sync_n), .div(cfg_div), .tick(tick)
  );

  sercom_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .push(tx_push), .wdata(wr_data),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  sercom_tx u_tx (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .nine(cfg_nine_bit),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .have_data(!tx_empty),
    .data(tx_head), .pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  sercom_rx u_rx (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .rxd(rxd), .nine(cfg_nine_bit),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .valid(rx_valid), .word(rx_word)
  );

  sercom_fifo #(.W(RXW_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    // transmit side (R2)
    tx_push  = wr_en && !tx_full;
    tx_ovf_d = tx_ovf_q || (wr_en && tx_full);
    // address filter (R9)
    addr_hit = (rx_word.data[7:0] == cfg_node_addr);
    keep     = !cfg_nine_bit || rx_word.brk || (rx_word.data[8] ? addr_hit : match_q);
    match_d  = match_q;
    if (rx_valid && cfg_nine_bit && rx_word.data[8] && !rx_word.brk) match_d = addr_hit;
    // receive queue (R11)
    rx_push  = rx_valid && keep && !rx_full;
    rx_ovr_d = rx_ovr_q || (rx_valid && keep && rx_full);
    // host read (R3, R4)
    rx_pop     = rd_en && !rx_empty;
    rx_udf_d   = rx_udf_q || (rd_en && rx_empty);
    rd_valid_d = rd_en;
    rd_word_d  = rd_word_q;
    if (rd_en) rd_word_d = rx_empty ? '0 : rx_head;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_ovf_q   <= 1'b0;
      rx_udf_q   <= 1'b0;
      rx_ovr_q   <= 1'b0;
      match_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_word_q  <= '0;
    end else begin
      tx_ovf_q   <= tx_ovf_d;
      rx_udf_q   <= rx_udf_d;
      rx_ovr_q   <= rx_ovr_d;
      match_q    <= match_d;
      rd_valid_q <= rd_valid_d;
      rd_word_q  <= rd_word_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_word_q.data;
  assign rd_perr  = rd_word_q.perr;
  assign rd_ferr  = rd_word_q.ferr;
  assign rd_brk   = rd_word_q.brk;
  assign tx_ovf   = tx_ovf_q;
  assign rx_udf   = rx_udf_q;
  assign rx_ovr   = rx_ovr_q;
endmodule

// File: rtl/sercom_uart_chk.sv
`timescale 1ns/1ps
module sercom_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       rx_empty,
  input logic       tx_ovf,
  input logic       rx_udf,
  input logic       rx_ovr,
  input logic       rd_valid,
  input logic [8:0] rd_data,
  input logic       rd_ferr,
  input logic       rd_brk,
  input logic       txd,
  input logic       tx_busy
);
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_full |=> tx_ovf);
  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);
  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty) && !(tx_full && tx_empty));
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rx_empty |=> rd_valid && (rd_data == 9'd0) && rx_udf);
  assert_brk_ferr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_brk |-> rd_ferr);
  assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> rx_ovr);
endmodule

bind sercom_uart sercom_uart_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_ovf(tx_ovf), .rx_udf(rx_udf), .rx_ovr(rx_ovr), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .txd(txd), .tx_busy(tx_busy)
);

// File: tb/sercom_uart_test.sv
`timescale 1ns/1ps
module sercom_uart_test;
  localparam int DIV  = 1;
  localparam int BITC = 16 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_div;
  logic        cfg_nine_bit, cfg_par_en, cfg_par_odd;
  logic [7:0]  cfg_node_addr;
  logic        wr_en, rd_en, rxd;
  logic [8:0]  wr_data, rd_data;
  logic        rd_valid, rd_perr, rd_ferr, rd_brk;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_ovf, rx_udf, rx_ovr, txd;

  int n_cmp = 0;
  int n_bad = 0;
  logic [11:0] rx_q[$];
  string       rx_tag_q[$];
  logic [8:0]  tx_q[$];

  sercom_uart uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nine_bit(cfg_nine_bit),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_node_addr(cfg_node_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .rx_udf(rx_udf), .rx_ovr(rx_ovr), .rxd(rxd), .txd(txd)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic par_of(logic [8:0] d);
    logic [8:0] m;
    m = cfg_nine_bit ? d : {1'b0, d[7:0]};
    return (^m) ^ cfg_par_odd;
  endfunction

  // driver: host write, expected line frame goes to the scoreboard
  task automatic host_wr(input logic [8:0] d, input bit accepted);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (accepted) tx_q.push_back(cfg_nine_bit ? d : {1'b0, d[7:0]});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: host read, expected {brk,ferr,perr,data} goes to the scoreboard
  task automatic host_rd(input logic [11:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    rx_q.push_back(exp);
    rx_tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input bit flip_par, input bit stop_v);
    int nb;
    nb = cfg_nine_bit ? 9 : 8;
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (BITC) @(negedge clk);
    end
    if (cfg_par_en) begin
      rxd = par_of(d) ^ flip_par;
      repeat (BITC) @(negedge clk);
    end
    rxd = stop_v;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    while (tx_q.size() > 0) @(negedge clk);
    repeat (2 * BITC) @(negedge clk);
  endtask

  // monitor: serial output decoder (R1, R5, R8)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        logic [8:0] got, ex;
        logic       pb, sb;
        int         nb;
        nb  = cfg_nine_bit ? 9 : 8;
        got = '0;
        pb  = 1'b0;
        repeat (BITC / 2) @(negedge clk);
        chk("R1 start bit low", txd, 0);
        for (int i = 0; i < nb; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = txd;
        end
        if (cfg_par_en) begin
          repeat (BITC) @(negedge clk);
          pb = txd;
        end
        repeat (BITC) @(negedge clk);
        sb = txd;
        if (tx_q.size() == 0) begin
          chk("R1 unexpected tx frame", {23'd0, got}, 32'hFFFF_FFFF);
        end else begin
          ex = tx_q.pop_front();
          chk("R1 R8 tx data bits", got, ex);
          if (cfg_par_en) chk("R5 tx parity bit", pb, par_of(ex));
          chk("R1 tx stop bit", sb, 1);
        end
      end
    end
  end

  // monitor: read return comparison (R3 ordering plus per-word status)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && rd_valid === 1'b1) begin
        if (rx_q.size() == 0) begin
          chk("R3 unexpected read return", rd_data, 32'hFFFF_FFFF);
        end else begin
          logic [11:0] ex;
          string       tg;
          ex = rx_q.pop_front();
          tg = rx_tag_q.pop_front();
          chk(tg, {rd_brk, rd_ferr, rd_perr, rd_data}, ex);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_div = 16'(DIV); cfg_nine_bit = 1'b0; cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0; cfg_node_addr = 8'h5A; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R1 reset txd idle", txd, 1);
    chk("R2 reset tx_empty", tx_empty, 1);
    chk("R2 reset tx_ovf", tx_ovf, 0);
    chk("R3 reset rx_empty", rx_empty, 1);
    chk("R4 reset rx_udf", rx_udf, 0);
    chk("R11 reset rx_ovr", rx_ovr, 0);

    // R4: read of empty queue
    host_rd(12'h000, "R4 empty read data");
    @(negedge clk);
    chk("R4 rx_udf sticky set", rx_udf, 1);

    // eight-bit, no parity (R1, R3, R8)
    host_wr(9'h1A5, 1'b1);
    host_wr(9'h03C, 1'b1);
    send_frame(9'h0A5, 1'b0, 1'b1);
    send_frame(9'h001, 1'b0, 1'b1);
    chk("R3 rx_empty low after frames", rx_empty, 0);
    host_rd(12'h0A5, "R3 R8 first word");
    host_rd(12'h001, "R3 second word");
    @(negedge clk);
    chk("R3 rx_empty after drain", rx_empty, 1);
    wait_tx_idle();

    // even parity (R5)
    cfg_par_en = 1'b1;
    host_wr(9'h007, 1'b1);
    send_frame(9'h007, 1'b0, 1'b1);
    send_frame(9'h007, 1'b1, 1'b1);
    host_rd(12'h007, "R5 even parity good");
    host_rd(12'h207, "R5 even parity bad");
    wait_tx_idle();

    // odd parity (R5)
    cfg_par_odd = 1'b1;
    host_wr(9'h000, 1'b1);
    send_frame(9'h081, 1'b0, 1'b1);
    send_frame(9'h081, 1'b1, 1'b1);
    host_rd(12'h081, "R5 odd parity good");
    host_rd(12'h281, "R5 odd parity bad");
    wait_tx_idle();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // framing error (R6)
    send_frame(9'h055, 1'b0, 1'b0);
    host_rd(12'h455, "R6 stop low");

    // break: one word only (R7)
    @(negedge clk);
    rxd = 1'b0;
    repeat (12 * BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    host_rd(12'hC00, "R7 break word");
    @(negedge clk);
    chk("R7 single break word", rx_empty, 1);

    // short low pulse ignored (R10)
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk("R10 glitch gives no word", rx_empty, 1);
    send_frame(9'h05E, 1'b0, 1'b1);
    host_rd(12'h05E, "R10 frame after glitch");

    // transmit queue overflow (R2)
    for (int i = 0; i < 10; i++) begin
      host_wr(9'(9'h040 + i), i < 9);
      if (i == 8) begin
        chk("R2 tx_full after nine writes", tx_full, 1);
        chk("R2 no overflow yet", tx_ovf, 0);
      end
    end
    @(negedge clk);
    chk("R2 overflow flagged", tx_ovf, 1);
    wait_tx_idle();
    chk("R2 tx_empty after drain", tx_empty, 1);
    chk("R2 overflow sticky", tx_ovf, 1);

    // receive queue overrun (R11)
    for (int i = 0; i < 9; i++) send_frame(9'(9'h010 + i), 1'b0, 1'b1);
    chk("R11 rx_full", rx_full, 1);
    chk("R11 rx_ovr set", rx_ovr, 1);
    for (int i = 0; i < 8; i++) host_rd(12'(12'h010 + i), "R11 kept words in order");
    @(negedge clk);
    chk("R11 ninth word dropped", rx_empty, 1);

    // nine-bit addressing (R8, R9)
    cfg_nine_bit = 1'b1;
    host_wr(9'h15A, 1'b1);
    host_wr(9'h033, 1'b1);
    send_frame(9'h011, 1'b0, 1'b1);
    send_frame(9'h133, 1'b0, 1'b1);
    send_frame(9'h15A, 1'b0, 1'b1);
    send_frame(9'h022, 1'b0, 1'b1);
    send_frame(9'h023, 1'b0, 1'b1);
    send_frame(9'h144, 1'b0, 1'b1);
    send_frame(9'h055, 1'b0, 1'b1);
    host_rd(12'h15A, "R9 R8 matching address kept");
    host_rd(12'h022, "R9 data after match");
    host_rd(12'h023, "R9 second data after match");
    @(negedge clk);
    chk("R9 filtered words absent", rx_empty, 1);
    wait_tx_idle();

    repeat (4) @(negedge clk);
    chk("R3 all reads returned", rx_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule